// File: doc/BRIEF.md
# Serial Converter Access Sequencer

This block is the host-side master for an 8-bit successive-approximation converter that is reached over a serial link. The link has an active-low select, a serial clock and a serial address line, and it returns data on one input. A client hands the block a 5-bit channel number through a valid/ready handshake. The block then runs one complete access. It lowers select, waits for the converter to settle on the new select level, and issues a burst of serial clock pulses. It shifts the channel number out, most significant bit first, and samples the eight returned data bits. It then raises select and keeps it high for the whole conversion gap before it accepts the next request.

The converter returns, in each access, the result of the conversion that the previous access started. The block therefore keeps the channel number of the previous access and attaches it to the data it reads. It also flags the first result after reset as carrying no real conversion.

A shared-clock mode serves boards where one clock drives both the converter's conversion logic and its serial port. In that mode the select settling wait is replaced by two leading pulses that carry no address, so each access has ten pulses in total.

Top module: `adcm_master`

## Requirements
- R1: While reset is asserted and right after it is released, select is high, the serial clock is low, the address line is low, `req_ready` is high and `res_valid` is low.
- R2: A request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` then stays low until the conversion gap of that access has ended, and a `req_valid` that is held high meanwhile starts no further access.
- R3: In normal mode, at least `CS_SETUP` (default 3) clock cycles pass between select going low and the first rising edge of the serial clock.
- R4: Each access issues exactly 8 serial clock pulses in normal mode. In shared-clock mode it issues exactly 10, and the first two of these are leading pulses.
- R5: On the first five non-leading pulses the address line carries the channel number, bit 4 first and bit 0 last. It is stable across each rising edge and is low on all other pulses.
- R6: The data input is sampled when each of the eight non-leading pulses rises. The first sample becomes bit 7 of the result and the last becomes bit 0.
- R7: One cycle after the falling edge of the last pulse, select goes high. It then stays high for at least `CONV_GAP` (default 36) cycles before it falls again, and the serial clock stays low the whole time select is high.
- R8: `res_chan` gives the channel that was addressed in the previous access. `res_ok` is 0 for the first access after reset and 1 for every access after that.
- R9: Each high phase and each low phase of a serial clock pulse lasts exactly `HALF` (default 2) clock cycles.
- R10: `res_valid` is a single-cycle pulse. It rises in the same cycle in which select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the converter's conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shared_mode | input | 1 | 1 selects shared-clock access (two leading pulses, no settling wait) |
| req_valid | input | 1 | A channel request is offered |
| req_chan | input | 5 | Channel to address in the next access |
| req_ready | output | 1 | Block is idle and takes a request |
| adc_cs_n | output | 1 | Active-low select to the converter |
| adc_ioclk | output | 1 | Serial clock to the converter |
| adc_addr | output | 1 | Serial address bit to the converter |
| adc_dout | input | 1 | Serial data bit from the converter |
| res_valid | output | 1 | One-cycle pulse: a result is presented |
| res_data | output | 8 | Result code read in the finished access |
| res_chan | output | 5 | Channel that produced `res_data` |
| res_ok | output | 1 | 1 when `res_data` comes from a real earlier conversion |

## Verification
If the pulse counter or the state register drifts, the block issues a wrong number of serial pulses, and the converter model sees this when select rises at the end of that same access. A fault in the address index or the data shift shows up first as a wrong captured channel at the eighth valid falling edge. It then shows up as a wrong result code one access later, because every result reflects the address sent one access earlier. A stale tag register shows up only in `res_chan`, so the bench runs sequences in which the channel changes on every access, which exposes such a fault on the very next result. A wait counter that is loaded with the wrong value shows up as a short select-settle interval, a short gap or an uneven pulse phase, and a cycle counter checks each of these as it happens.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LO,
    ST_HI,
    ST_TAIL,
    ST_GAP
  } adcm_state_e;
endpackage

// File: rtl/adcm_wait.sv
module adcm_wait #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)            cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/adcm_rxshift.sv
module adcm_rxshift #(
  parameter int D_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           din,
  output logic [D_W-1:0] q
);
  logic [D_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = {q[D_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/adcm_master.sv
module adcm_master
  import adcm_pkg::*;
#(
  parameter int HALF     = 2,
  parameter int CS_SETUP = 3,
  parameter int CONV_GAP = 36,
  parameter int CH_W     = 5,
  parameter int D_W      = 8,
  parameter int LEAD     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shared_mode,
  input  logic            req_valid,
  input  logic [CH_W-1:0] req_chan,
  output logic            req_ready,
  output logic            adc_cs_n,
  output logic            adc_ioclk,
  output logic            adc_addr,
  input  logic            adc_dout,
  output logic            res_valid,
  output logic [D_W-1:0]  res_data,
  output logic [CH_W-1:0] res_chan,
  output logic            res_ok
);
  localparam int MAXV  = (CONV_GAP > CS_SETUP) ? ((CONV_GAP > HALF) ? CONV_GAP : HALF)
                                               : ((CS_SETUP > HALF) ? CS_SETUP : HALF);
  localparam int CNT_W = $clog2(MAXV + 1);
  localparam int PC_W  = $clog2(D_W + LEAD + 1);
  localparam int HC_W  = $clog2(CONV_GAP + 1);
  localparam int LC_W  = $clog2(CS_SETUP + 1);

  adcm_state_e     st_q, st_d;
  logic [PC_W-1:0] pulse_q, pulse_d, lead_eff, vidx, last_pulse;
  logic [CH_W-1:0] chan_q, prev_q, addr_sh;
  logic            shared_q, have_prev_q;
  logic            w_load, w_done;
  logic [CNT_W-1:0] w_val;
  logic            rx_en;
  logic [D_W-1:0]  rx_q;
  logic            accept, in_pulse, addr_phase;

  // per-access geometry: leading pulses only in shared-clock mode
  assign lead_eff   = shared_q ? PC_W'(LEAD) : '0;
  assign vidx       = pulse_q - lead_eff;
  assign last_pulse = PC_W'(D_W - 1) + lead_eff;
  assign in_pulse   = (st_q == ST_LO) || (st_q == ST_HI);
  assign addr_phase = in_pulse && (pulse_q >= lead_eff) && (vidx < PC_W'(CH_W));
  assign addr_sh    = chan_q << vidx;
  assign accept     = (st_q == ST_IDLE) && req_valid;

  assign req_ready  = (st_q == ST_IDLE);
  assign adc_cs_n   = (st_q == ST_IDLE) || (st_q == ST_GAP);
  assign adc_ioclk  = (st_q == ST_HI);
  assign adc_addr   = addr_phase & addr_sh[CH_W-1];

  adcm_wait #(.W(CNT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(w_load), .load_val(w_val), .done(w_done)
  );

  adcm_rxshift #(.D_W(D_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .din(adc_dout), .q(rx_q)
  );

  always_comb begin
    st_d    = st_q;
    pulse_d = pulse_q;
    w_load  = 1'b0;
    w_val   = '0;
    rx_en   = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        w_load  = 1'b1;
        pulse_d = '0;
        if (shared_mode) begin
          st_d  = ST_LO;
          w_val = CNT_W'(HALF - 1);
        end else begin
          st_d  = ST_SETUP;
          w_val = CNT_W'(CS_SETUP - 1);
        end
      end
      ST_SETUP: if (w_done) begin
        st_d   = ST_LO;
        w_load = 1'b1;
        w_val  = CNT_W'(HALF - 1);
      end
      ST_LO: if (w_done) begin
        st_d   = ST_HI;
        w_load = 1'b1;
        w_val  = CNT_W'(HALF - 1);
        rx_en  = (pulse_q >= lead_eff);
      end
      ST_HI: if (w_done) begin
        pulse_d = pulse_q + 1'b1;
        if (pulse_q == last_pulse) begin
          st_d = ST_TAIL;
        end else begin
          st_d   = ST_LO;
          w_load = 1'b1;
          w_val  = CNT_W'(HALF - 1);
        end
      end
      ST_TAIL: begin
        st_d   = ST_GAP;
        w_load = 1'b1;
        w_val  = CNT_W'(CONV_GAP - 1);
      end
      ST_GAP: if (w_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pulse_q <= '0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q   <= '0;
      shared_q <= 1'b0;
    end else if (accept) begin
      chan_q   <= req_chan;
      shared_q <= shared_mode;
    end
  end

  // result carries the tag of the access before this one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_chan    <= '0;
      res_ok      <= 1'b0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else begin
      res_valid <= (st_q == ST_TAIL);
      if (st_q == ST_TAIL) begin
        res_data    <= rx_q;
        res_chan    <= prev_q;
        res_ok      <= have_prev_q;
        prev_q      <= chan_q;
        have_prev_q <= 1'b1;
      end
    end
  end

  // interval counters watched by the properties below
  logic [HC_W-1:0] hi_cnt;
  logic [LC_W-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= HC_W'(CONV_GAP);
      lo_cnt <= '0;
    end else begin
      if (adc_cs_n) hi_cnt <= (hi_cnt == HC_W'(CONV_GAP)) ? hi_cnt : hi_cnt + 1'b1;
      else          hi_cnt <= '0;
      if (!adc_cs_n) lo_cnt <= (lo_cnt == LC_W'(CS_SETUP)) ? lo_cnt : lo_cnt + 1'b1;
      else           lo_cnt <= '0;
    end
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_cs_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adc_ioclk) && !shared_q && pulse_q == '0) |-> (lo_cnt >= LC_W'(CS_SETUP)));

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_ioclk) |-> $stable(adc_addr));

  p_conv_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (hi_cnt >= HC_W'(CONV_GAP)));

  p_res_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_res_at_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(adc_cs_n));
endmodule

// File: tb/adcm_master_tb.sv
module adcm_master_tb;
  localparam int HALF     = 2;
  localparam int CS_SETUP = 3;
  localparam int CONV_GAP = 36;
  localparam int NV       = 8;

  localparam logic [4:0] VCH [NV] = '{5'd0, 5'd31, 5'd19, 5'd10, 5'd21, 5'd1, 5'd7, 5'd30};
  localparam logic       VSH [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, shared_mode, req_valid, req_ready;
  logic [4:0] req_chan, res_chan;
  logic       adc_cs_n, adc_ioclk, adc_addr, res_valid, res_ok;
  logic       adc_dout = 1'b0;
  logic [7:0] res_data;

  adcm_master #(.HALF(HALF), .CS_SETUP(CS_SETUP), .CONV_GAP(CONV_GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode),
    .req_valid(req_valid), .req_chan(req_chan), .req_ready(req_ready),
    .adc_cs_n(adc_cs_n), .adc_ioclk(adc_ioclk), .adc_addr(adc_addr),
    .adc_dout(adc_dout), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .res_ok(res_ok)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] code_of(input logic [4:0] ch);
    return {ch, ch[4:2]};
  endfunction

  // converter model: MSB out at select fall, next bit on each valid fall
  logic       armed = 1'b0;
  logic       cs_low_seen = 1'b0;
  int         edge_n = 0;
  int         vpos = 0;
  logic [4:0] cap = '0;
  logic [4:0] cur_ch = '0;
  logic [7:0] held = 8'h00;

  always @(negedge adc_cs_n or posedge adc_cs_n or posedge adc_ioclk or negedge adc_ioclk) begin
    if (adc_cs_n) begin
      if (armed && cs_low_seen)
        check(edge_n == (shared_mode ? 10 : 8), "R4 pulse count", edge_n, shared_mode ? 10 : 8);
      cs_low_seen = 1'b0;
    end else if (!cs_low_seen) begin
      cs_low_seen = 1'b1;
      edge_n = 0;
      adc_dout = held[7];
    end else if (adc_ioclk) begin
      edge_n++;
      vpos = edge_n - (shared_mode ? 2 : 0);
      if (vpos >= 1 && vpos <= 5) cap = {cap[3:0], adc_addr};
    end else begin
      vpos = edge_n - (shared_mode ? 2 : 0);
      if (vpos >= 1 && vpos <= 7) adc_dout = held[7-vpos];
      if (vpos == 8) begin
        check(cap == cur_ch, "R5 address", cap, cur_ch);
        held = code_of(cap);
      end
    end
  end

  // timing monitor, sampled between edges
  logic prev_cs = 1'b1;
  logic prev_io = 1'b0;
  logic first_rise = 1'b0;
  logic seen_fall = 1'b0;
  int   since_fall = 0;
  int   hi_cs = 0;
  int   hi_len = 0;
  int   n_fall = 0;

  always @(negedge clk) begin
    if (armed && rst_n) begin
      if (!adc_cs_n && prev_cs) begin
        if (seen_fall) check(hi_cs >= CONV_GAP, "R7 gap", hi_cs, CONV_GAP);
        seen_fall = 1'b1;
        since_fall = 0;
        first_rise = 1'b1;
        n_fall++;
      end
      if (adc_cs_n && !prev_cs) hi_cs = 0;
      if (adc_cs_n) hi_cs++;
      else          since_fall++;
      if (adc_ioclk && !prev_io) begin
        if (first_rise && !shared_mode)
          check(since_fall - 1 >= CS_SETUP, "R3 select settle", since_fall - 1, CS_SETUP);
        first_rise = 1'b0;
        hi_len = 0;
      end
      if (adc_ioclk) hi_len++;
      if (!adc_ioclk && prev_io) check(hi_len == HALF, "R9 high phase", hi_len, HALF);
      if (adc_cs_n && adc_ioclk) check(1'b0, "R7 clock while deselected", 1, 0);
      prev_cs = adc_cs_n;
      prev_io = adc_ioclk;
    end
  end

  task automatic wait_result();
    while (!res_valid) @(negedge clk);
  endtask

  task automatic run_access(input logic [4:0] ch, input logic sh, input logic [7:0] ed,
                            input logic [4:0] ec, input logic eok);
    @(negedge clk);
    shared_mode = sh;
    while (!req_ready) @(negedge clk);
    cur_ch    = ch;
    req_chan  = ch;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2 busy after accept", req_ready, 0);
    wait_result();
    check(res_ok == eok, "R8 ok flag", res_ok, eok);
    if (eok) begin
      check(res_chan == ec, "R8 tag", res_chan, ec);
      check(res_data == ed, "R6 data", res_data, ed);
    end
    check(adc_cs_n == 1'b1, "R10 select high with result", adc_cs_n, 1);
    @(negedge clk);
    check(!res_valid, "R10 single pulse", res_valid, 0);
  endtask

  task automatic check_idle(input string tag);
    check(adc_cs_n == 1'b1, {tag, " R1 select"}, adc_cs_n, 1);
    check(adc_ioclk == 1'b0, {tag, " R1 clock"}, adc_ioclk, 0);
    check(adc_addr == 1'b0, {tag, " R1 addr"}, adc_addr, 0);
    check(req_ready == 1'b1, {tag, " R1 ready"}, req_ready, 1);
    check(res_valid == 1'b0, {tag, " R1 result"}, res_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [4:0] pch;
  int         f0;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_chan = '0; shared_mode = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("after reset");
    armed = 1'b1;

    // table walk: channel changes every access, modes interleaved
    for (int i = 0; i < NV; i++) begin
      pch = (i == 0) ? 5'd0 : VCH[i-1];
      run_access(VCH[i], VSH[i], code_of(pch), pch, (i != 0));
    end

    // R2: request held high across two accesses
    f0 = n_fall;
    @(negedge clk);
    shared_mode = 1'b0;
    cur_ch = 5'd12; req_chan = 5'd12; req_valid = 1'b1;
    wait_result();
    check(res_chan == VCH[NV-1], "R8 tag held-valid", res_chan, VCH[NV-1]);
    req_chan = 5'd25;
    check(!req_ready, "R2 not ready in gap", req_ready, 0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_ch = 5'd25;
    @(negedge clk);
    req_valid = 1'b0;
    wait_result();
    check(res_chan == 5'd12, "R8 tag second", res_chan, 12);
    check(res_data == code_of(5'd12), "R6 data second", res_data, code_of(5'd12));
    check(n_fall - f0 == 2, "R2 accesses started", n_fall - f0, 2);

    // reset while idle: next result has no real conversion behind it
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("mid reset");
    rst_n = 1'b1;
    @(negedge clk);
    run_access(5'd3, 1'b0, 8'h00, 5'd0, 1'b0);
    run_access(5'd9, 1'b1, code_of(5'd3), 5'd3, 1'b1);
    run_access(5'd31, 1'b0, code_of(5'd9), 5'd9, 1'b1);
    run_access(5'd0, 1'b0, code_of(5'd31), 5'd31, 1'b1);

    repeat (45) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule